// File: doc/BRIEF.md
# Fast Ethernet Transmit Code-Group Encoder

This block sits between a MAC's transmit nibble interface and the serializer of a 100 Mb/s copper or fiber link. On each nibble clock it takes a transmit-enable flag and one data nibble, and it produces one 5-bit code-group. While the MAC is silent, the block fills the line with Idle. When a frame begins, the block overwrites the first preamble octet with the start-of-stream pair J, K. It encodes every later nibble through the 4B/5B table. When transmit-enable falls, it closes the stream with the end pair T, R.

Two run-time options change the datapath. In symbol mode, the MAC drives a fifth data bit and its 5-bit value goes to the output with no table lookup and no framing. With the scrambler enabled, every code-group leaves the block XORed with a keystream from an 11-bit linear feedback shift register. In bypass mode, the code-groups leave unchanged. The keystream generator advances on every clock, including during Idle.

Top module: `fe_tx_coder`

## Requirements
- R1: While no frame is in progress and `tx_en` is low, the pre-scrambler code-group is Idle, 5'b11111. Each output is registered and appears on `code` one clock after the inputs it depends on are sampled.
- R2: On the first clock with `tx_en` high after Idle, the block emits J (5'b11000). On the next clock it emits K (5'b10001). The data nibble is ignored in both slots.
- R3: After J and K, each clock with `tx_en` high emits the 4B/5B code of `txd`. The codes are 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R4: The first data-phase clock with `tx_en` low emits T (5'b01101). The next clock emits R (5'b00111), whatever the value of `tx_en`. After that the block is in Idle, so a `tx_en` seen in the R slot takes effect only on the following clock, as a fresh J.
- R5: With `sym_mode` high, the pre-scrambler code-group is {`txd_x`, `txd`} when `tx_en` is high and Idle when it is low. No J, K, T or R is inserted.
- R6: With `scr_bypass` low, `code` is the code-group XORed with a 5-bit key. Each clock the 11-bit register s takes five steps of fb = s[10]^s[8], s = {s[9:0], fb}. The fb of step i (i = 0..4) is key bit 4-i. The register advances on every clock outside reset.
- R7: With `scr_bypass` high, `code` equals the unscrambled code-group.
- R8: While `rst` is high, `code` is 5'b11111 on each clock. The framing returns to Idle and the key register is loaded with `SEED` (default 11'h7FF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | MAC transmit enable |
| txd | input | 4 | Transmit data nibble, low nibble of each octet first |
| txd_x | input | 1 | Fifth data bit, used only in symbol mode |
| sym_mode | input | 1 | 1: 5-bit passthrough without mapping or framing |
| scr_bypass | input | 1 | 1: output code-groups unscrambled |
| code | output | 5 | Registered 5-bit code-group |

## Verification
The end-of-stream delimiter and the start of the next frame can fall into adjacent slots. The bench provokes this by raising `tx_en` again during the R slot. It expects R and then J, with no Idle between them. A second collision is a frame that ends right after J. The bench drops `tx_en` during the K slot and expects K, T and R in that order. Both cases are run with the scrambler bypassed and with it active. A bench model built from R1 to R8 predicts every output, so the keystream step and the framing step are judged together in the same cycle.

// File: rtl/fe_pcs_pkg.sv
package fe_pcs_pkg;

   localparam int GRP_W = 5;
   typedef logic [GRP_W-1:0] grp_t;

   localparam grp_t GRP_IDLE = 5'b11111;
   localparam grp_t GRP_J    = 5'b11000;
   localparam grp_t GRP_K    = 5'b10001;
   localparam grp_t GRP_T    = 5'b01101;
   localparam grp_t GRP_R    = 5'b00111;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_K    = 2'd1,
      FS_DATA = 2'd2,
      FS_R    = 2'd3
   } fstate_e;

   function automatic grp_t nib_to_grp(input logic [3:0] n);
      grp_t g;
      case (n)
         4'h0: g = 5'b11110;
         4'h1: g = 5'b01001;
         4'h2: g = 5'b10100;
         4'h3: g = 5'b10101;
         4'h4: g = 5'b01010;
         4'h5: g = 5'b01011;
         4'h6: g = 5'b01110;
         4'h7: g = 5'b01111;
         4'h8: g = 5'b10010;
         4'h9: g = 5'b10011;
         4'hA: g = 5'b10110;
         4'hB: g = 5'b10111;
         4'hC: g = 5'b11010;
         4'hD: g = 5'b11011;
         4'hE: g = 5'b11100;
         default: g = 5'b11101;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/fe_nib_map.sv
module fe_nib_map #(
   parameter int NW = 4,
   parameter int CW = 5
) (
   input  logic [NW-1:0] nib,
   input  logic          ext,
   output logic [CW-1:0] data_grp,
   output logic [CW-1:0] raw_grp
);
   import fe_pcs_pkg::*;

   if (NW != 4) begin : g_bad_nw
      $error("fe_nib_map: NW must be 4");
   end
   if (CW != NW + 1) begin : g_bad_cw
      $error("fe_nib_map: CW must be NW+1");
   end

   always_comb begin
      data_grp = nib_to_grp(nib);
      raw_grp  = {ext, nib};
   end

endmodule

// File: rtl/fe_frame_ctl.sv
module fe_frame_ctl #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tx_en,
   input  logic          sym_mode,
   input  logic [CW-1:0] data_grp,
   input  logic [CW-1:0] raw_grp,
   output logic [CW-1:0] grp,
   output logic          at_idle,
   output logic          in_data
);
   import fe_pcs_pkg::*;

   fstate_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      grp  = GRP_IDLE;
      if (sym_mode) begin
         st_d = FS_IDLE;
         grp  = tx_en ? raw_grp : GRP_IDLE;
      end else begin
         case (st_q)
            FS_IDLE: begin
               if (tx_en) begin
                  grp  = GRP_J;
                  st_d = FS_K;
               end
            end
            FS_K: begin
               grp  = GRP_K;
               st_d = FS_DATA;
            end
            FS_DATA: begin
               if (tx_en) begin
                  grp = data_grp;
               end else begin
                  grp  = GRP_T;
                  st_d = FS_R;
               end
            end
            default: begin
               grp  = GRP_R;
               st_d = FS_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= FS_IDLE;
      else     st_q <= st_d;
   end

   assign at_idle = (st_q == FS_IDLE);
   assign in_data = (st_q == FS_DATA);

   // Framing leaves the data phase only through T then R (R4)
   assert_data_exit_R4: assert property (@(posedge clk) disable iff (rst)
      (in_data && !tx_en && !sym_mode) |=> (st_q == FS_R));

endmodule

// File: rtl/fe_scrambler.sv
module fe_scrambler #(
   parameter int          CW   = 5,
   parameter int          LW   = 11,
   parameter int          TAP  = 9,
   parameter logic [LW-1:0] SEED = '1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bypass,
   input  logic [CW-1:0] din,
   output logic [CW-1:0] dout
);
   if (TAP >= LW || TAP < 1) begin : g_bad_tap
      $error("fe_scrambler: TAP must lie in 1..LW-1");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("fe_scrambler: SEED must be non-zero");
   end
   if (CW > LW) begin : g_bad_cw
      $error("fe_scrambler: CW must not exceed LW");
   end

   logic [LW-1:0] lfsr_q;
   logic [LW-1:0] chain [CW+1];
   logic [CW-1:0] key;

   assign chain[0] = lfsr_q;

   for (genvar i = 0; i < CW; i++) begin : g_step
      logic fb;
      assign fb           = chain[i][LW-1] ^ chain[i][TAP-1];
      assign chain[i+1]   = {chain[i][LW-2:0], fb};
      assign key[CW-1-i]  = fb;
   end

   always_ff @(posedge clk) begin
      if (rst) lfsr_q <= SEED;
      else     lfsr_q <= chain[CW];
   end

   assign dout = bypass ? din : (din ^ key);

   // A non-zero seed keeps the register out of the all-zero lockup (R6)
   assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (rst)
      lfsr_q != '0);

endmodule

// File: rtl/fe_tx_coder.sv
module fe_tx_coder #(
   parameter int            NW   = 4,
   parameter int            CW   = 5,
   parameter int            LW   = 11,
   parameter int            TAP  = 9,
   parameter logic [10:0]   SEED = 11'h7FF
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tx_en,
   input  logic [NW-1:0] txd,
   input  logic          txd_x,
   input  logic          sym_mode,
   input  logic          scr_bypass,
   output logic [CW-1:0] code
);
   import fe_pcs_pkg::*;

   localparam logic [LW-1:0] SEED_W = LW'(SEED);

   if (CW != GRP_W) begin : g_bad_grp
      $error("fe_tx_coder: CW must match the code-group width");
   end

   logic [CW-1:0] data_grp, raw_grp, frm_grp, scr_grp;
   logic          at_idle, in_data;
   logic [CW-1:0] code_q;

   fe_nib_map #(.NW(NW), .CW(CW)) i_map (
      .nib      (txd),
      .ext      (txd_x),
      .data_grp (data_grp),
      .raw_grp  (raw_grp)
   );

   fe_frame_ctl #(.CW(CW)) i_frame (
      .clk      (clk),
      .rst      (rst),
      .tx_en    (tx_en),
      .sym_mode (sym_mode),
      .data_grp (data_grp),
      .raw_grp  (raw_grp),
      .grp      (frm_grp),
      .at_idle  (at_idle),
      .in_data  (in_data)
   );

   fe_scrambler #(.CW(CW), .LW(LW), .TAP(TAP), .SEED(SEED_W)) i_scr (
      .clk    (clk),
      .rst    (rst),
      .bypass (scr_bypass),
      .din    (frm_grp),
      .dout   (scr_grp)
   );

   always_ff @(posedge clk) begin
      if (rst) code_q <= GRP_IDLE;
      else     code_q <= scr_grp;
   end

   assign code = code_q;

   assert_reset_idle_R8: assert property (@(posedge clk)
      rst |=> (code == GRP_IDLE));

   assert_idle_fill_R1: assert property (@(posedge clk) disable iff (rst)
      (at_idle && !tx_en && scr_bypass) |=> (code == GRP_IDLE));

   assert_start_j_R2: assert property (@(posedge clk) disable iff (rst)
      (at_idle && tx_en && !sym_mode && scr_bypass) |=> (code == GRP_J));

   assert_end_t_R4: assert property (@(posedge clk) disable iff (rst)
      (in_data && !tx_en && !sym_mode && scr_bypass) |=> (code == GRP_T));

   assert_sym_pass_R5: assert property (@(posedge clk) disable iff (rst)
      (sym_mode && tx_en && scr_bypass) |=> (code == $past({txd_x, txd})));

endmodule

// File: tb/test_fe_tx_coder.sv
`timescale 1ns/1ps
module test_fe_tx_coder;

   localparam logic [10:0] SEED = 11'h7FF;
   localparam logic [4:0] C_IDLE = 5'b11111, C_J = 5'b11000, C_K = 5'b10001,
                          C_T = 5'b01101, C_R = 5'b00111;
   localparam logic [4:0] TBL [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                       5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                       5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                       5'b11010, 5'b11011, 5'b11100, 5'b11101};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tx_en = 1'b0;
   logic [3:0] txd = 4'h0;
   logic       txd_x = 1'b0;
   logic       sym_mode = 1'b0;
   logic       scr_bypass = 1'b1;
   logic [4:0] code;

   int total = 0;
   int bad   = 0;

   int          m_st = 0;
   logic [10:0] m_lfsr = SEED;

   always #4 clk = ~clk;

   fe_tx_coder i_fe_tx_coder (
      .clk(clk), .rst(rst), .tx_en(tx_en), .txd(txd), .txd_x(txd_x),
      .sym_mode(sym_mode), .scr_bypass(scr_bypass), .code(code)
   );

   task automatic check(input logic [4:0] exp, input string req);
      total++;
      if (code !== exp) begin
         bad++;
         $display("FAIL %s: code=%b expected=%b", req, code, exp);
      end
   endtask

   // One nibble clock: drive at negedge, predict, sample at next negedge
   task automatic cyc(input logic en, input logic [3:0] d, input logic x, input string req);
      logic [4:0] raw, key, exp;
      logic [10:0] s;
      logic fb;
      tx_en = en; txd = d; txd_x = x;
      if (sym_mode) begin
         raw = en ? {x, d} : C_IDLE;
         m_st = 0;
      end else begin
         case (m_st)
            0: begin raw = en ? C_J : C_IDLE; if (en) m_st = 1; end
            1: begin raw = C_K; m_st = 2; end
            2: begin
               if (en) raw = TBL[d];
               else begin raw = C_T; m_st = 3; end
            end
            default: begin raw = C_R; m_st = 0; end
         endcase
      end
      s = m_lfsr;
      for (int i = 0; i < 5; i++) begin
         fb = s[10] ^ s[8];
         key[4-i] = fb;
         s = {s[9:0], fb};
      end
      m_lfsr = s;
      exp = scr_bypass ? raw : (raw ^ key);
      @(posedge clk);
      @(negedge clk);
      check(exp, req);
   endtask

   task automatic do_reset();
      rst = 1'b1; tx_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(C_IDLE, "R8 reset output");
      @(posedge clk);
      @(negedge clk);
      check(C_IDLE, "R8 reset output held");
      rst = 1'b0;
      m_st = 0;
      m_lfsr = SEED;
   endtask

   task automatic frame(input int nnib, input int base, input string req);
      cyc(1'b1, 4'h5, 1'b0, "R2 J slot");
      cyc(1'b1, 4'h5, 1'b0, "R2 K slot");
      for (int i = 0; i < nnib; i++) cyc(1'b1, 4'((base + i) % 16), 1'b0, req);
      cyc(1'b0, 4'h0, 1'b0, "R4 T slot");
      cyc(1'b0, 4'h0, 1'b0, "R4 R slot");
   endtask

   initial begin
      #(200000 * 8);
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();

      // bypassed scrambler: framing seen directly
      for (int i = 0; i < 4; i++) cyc(1'b0, 4'(i), 1'b0, "R1 idle fill");
      for (int b = 0; b < 3; b++) frame(16, b * 5, "R3 data map");
      cyc(1'b0, 4'h0, 1'b0, "R7 idle bypassed");

      // collision: tx_en re-raised in the R slot
      cyc(1'b1, 4'h5, 1'b0, "R2 J slot");
      cyc(1'b1, 4'h5, 1'b0, "R2 K slot");
      cyc(1'b1, 4'hD, 1'b0, "R3 data");
      cyc(1'b0, 4'h0, 1'b0, "R4 T slot");
      cyc(1'b1, 4'h0, 1'b0, "R4 R slot ignores tx_en");
      cyc(1'b1, 4'h0, 1'b0, "R4 new J after R");
      cyc(1'b0, 4'h0, 1'b0, "R4 K after early drop");
      cyc(1'b0, 4'h0, 1'b0, "R4 T after early drop");
      cyc(1'b0, 4'h0, 1'b0, "R4 R after early drop");
      cyc(1'b0, 4'h0, 1'b0, "R1 idle after R");

      // symbol mode, all 32 values
      sym_mode = 1'b1;
      for (int v = 0; v < 32; v++) begin
         cyc(1'b1, 4'(v), 1'(v >> 4), "R5 symbol passthrough");
         if (v % 8 == 7) cyc(1'b0, 4'hF, 1'b1, "R5 symbol idle");
      end
      sym_mode = 1'b0;
      cyc(1'b0, 4'h0, 1'b0, "R1 idle");

      // scrambler active
      scr_bypass = 1'b0;
      for (int i = 0; i < 6; i++) cyc(1'b0, 4'h0, 1'b0, "R6 scrambled idle");
      for (int b = 0; b < 2; b++) frame(16, b * 3, "R6 scrambled data");
      cyc(1'b1, 4'h0, 1'b0, "R6 scrambled J");
      cyc(1'b1, 4'h0, 1'b0, "R6 scrambled K");
      cyc(1'b0, 4'h0, 1'b0, "R6 scrambled T");
      cyc(1'b1, 4'h0, 1'b0, "R6 scrambled R with tx_en");
      cyc(1'b1, 4'h0, 1'b0, "R6 scrambled J again");
      cyc(1'b1, 4'h0, 1'b0, "R6 scrambled K again");
      cyc(1'b0, 4'h0, 1'b0, "R6 scrambled T again");
      cyc(1'b0, 4'h0, 1'b0, "R6 scrambled R again");
      sym_mode = 1'b1;
      for (int v = 0; v < 32; v++) cyc(1'b1, 4'(v), 1'(v >> 4), "R6 scrambled symbol");
      sym_mode = 1'b0;
      cyc(1'b0, 4'h0, 1'b0, "R6 scrambled idle");

      // reset in the middle of a frame
      cyc(1'b1, 4'h0, 1'b0, "R2 J slot");
      cyc(1'b1, 4'h0, 1'b0, "R2 K slot");
      cyc(1'b1, 4'h9, 1'b0, "R3 data");
      do_reset();
      cyc(1'b0, 4'h0, 1'b0, "R8 key reloaded");
      frame(5, 7, "R8 framing cleared");
      scr_bypass = 1'b1;
      cyc(1'b0, 4'h0, 1'b0, "R7 bypass restored");
      frame(4, 12, "R7 bypass frame");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule